// File: doc/BRIEF.md
# Edge/Level Interrupt Request Register

This block keeps the pending-request state for eight interrupt lines. A trigger-mode register sets, line by line, how a request is recognised. A level-sensitive line has its pending bit follow the input. An edge-sensitive line latches a request on a rising input and holds it until the line is acknowledged. For each line the block remembers the level it last sampled. A line event is any sampled input that differs from that remembered level.

For every line event the block returns a registered status, valid one cycle after the input changed. The status tells whether the line was masked at that moment and whether the event raised a request that was not already pending. An acknowledge strobe with a line index retires edge-mode requests. A history-clear strobe forgets every remembered level, so that an input held high is seen as a new edge afterwards. Software writes and reads the trigger-mode register through a byte port. Only a fixed set of bits can be written, and a parameter selects the primary or the secondary set.

Top module: `edge_level_irr`

## Requirements
- R1: Trigger-mode bit n set to 1 makes line n level-sensitive, and 0 makes it edge-sensitive. The register reads back on `mode_rdata_o` with bit n standing for line n.
- R2: On a level-sensitive line, the pending bit after each clock edge equals the input sampled at that edge. Acknowledge has no effect on it.
- R3: On an edge-sensitive line, the pending bit sets when the input is 1 and the remembered level is 0. A falling input updates only the remembered level and leaves the pending bit unchanged.
- R4: A sampled input that differs from the remembered level is an event. One cycle later `evt_valid_o[n]` is 1 for that event. `evt_masked_o[n]` copies `mask_i[n]`. `evt_fresh_o[n]` is 1 only for an unmasked rising event on a line whose pending bit was 0. All three flags are 0 on lines without an event.
- R5: A trigger-mode write stores `mode_wdata_i` ANDed with the writable mask. The mask is 8'hF8 when `SECONDARY` is 0 and 8'hDE when it is 1.
- R6: An acknowledge clears the pending bit of line `ack_line_i` only if that line is edge-sensitive. A rising event on the same line in the same cycle wins, and the bit stays set.
- R7: A history-clear cycle sets every remembered level to 0, keeps the pending bits apart from acknowledge clears, and reports no events. An edge line held high therefore raises a new request one cycle later.
- R8: Reset, asynchronous and active-low, clears the pending bits, the remembered levels, the status flags and the trigger-mode register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Synchronous request inputs, one per line |
| mask_i | input | 8 | Per-line mask, used for status reporting |
| ack_i | input | 1 | Acknowledge strobe |
| ack_line_i | input | 3 | Index of the acknowledged line |
| hist_clr_i | input | 1 | Clear all remembered levels |
| mode_we_i | input | 1 | Trigger-mode register write strobe |
| mode_wdata_i | input | 8 | Trigger-mode write data |
| mode_rdata_o | output | 8 | Trigger-mode register contents |
| pend_o | output | 8 | Pending-request vector |
| evt_valid_o | output | 8 | Line had an event last cycle |
| evt_masked_o | output | 8 | Event occurred on a masked line |
| evt_fresh_o | output | 8 | Event raised a request that was not pending |

## Verification
The bench checks that a falling edge-mode input keeps its request while a falling level-mode input drops it. A design that treated both modes alike would fail one of these cases. It acknowledges a level line and expects the bit to survive, then sets and acknowledges one edge line in the same cycle and expects the set to win. A design that gave the acknowledge priority would lose that request. A history clear with an edge input held high must produce a second fresh request. A design that ignored the clear would show no event. Writes of all ones and of a sparse pattern to both the primary and the secondary instance expose a wrong or missing writable mask.

// File: rtl/irr_pkg.sv
package irr_pkg;
  localparam int NLINES = 8;
  localparam int IDX_W  = $clog2(NLINES);

  function automatic logic [NLINES-1:0] writable_mask(input bit secondary);
    writable_mask = secondary ? 8'hDE : 8'hF8;
  endfunction
endpackage

// File: rtl/irr_mode_reg.sv
module irr_mode_reg
  import irr_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [NLINES-1:0] wdata,
  output logic [NLINES-1:0] mode_q
);
  localparam logic [NLINES-1:0] WMASK = writable_mask(SECONDARY);

  logic [NLINES-1:0] mode_d;

  always_comb begin
    mode_d = mode_q;
    if (we) mode_d = wdata & WMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= mode_d;
  end

  // R5: stored value is the written byte filtered by the writable mask
  p_mode_filter_r5: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mode_q == ($past(wdata) & WMASK));
endmodule

// File: rtl/irr_ack_dec.sv
module irr_ack_dec
  import irr_pkg::*;
(
  input  logic             ack,
  input  logic [IDX_W-1:0] ack_line,
  output logic [NLINES-1:0] ack_hit
);
  for (genvar g = 0; g < NLINES; g++) begin : g_hit
    assign ack_hit[g] = ack && (ack_line == IDX_W'(g));
  end

  always_comb begin
    a_ack_onehot_r6: assert ($onehot0(ack_hit));
  end
endmodule

// File: rtl/irr_line.sv
module irr_line (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic mask,
  input  logic level_mode,
  input  logic ack_hit,
  input  logic hist_clr,
  output logic pend,
  output logic evt_valid,
  output logic evt_masked,
  output logic evt_fresh
);
  logic last_q, last_d;
  logic pend_d;
  logic valid_d, masked_d, fresh_d;
  logic rise, change;

  assign rise   = req & ~last_q;
  assign change = req ^ last_q;

  always_comb begin
    last_d   = last_q;
    pend_d   = pend;
    valid_d  = 1'b0;
    masked_d = 1'b0;
    fresh_d  = 1'b0;
    if (hist_clr) begin
      last_d = 1'b0;
      if (ack_hit && !level_mode) pend_d = 1'b0;
    end else begin
      last_d   = req;
      valid_d  = change;
      masked_d = change & mask;
      fresh_d  = rise & ~mask & ~pend;
      if (level_mode)   pend_d = req;
      else if (rise)    pend_d = 1'b1;
      else if (ack_hit) pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q     <= 1'b0;
      pend       <= 1'b0;
      evt_valid  <= 1'b0;
      evt_masked <= 1'b0;
      evt_fresh  <= 1'b0;
    end else begin
      last_q     <= last_d;
      pend       <= pend_d;
      evt_valid  <= valid_d;
      evt_masked <= masked_d;
      evt_fresh  <= fresh_d;
    end
  end

  // R2: level line tracks its input
  p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && !hist_clr) |=> pend == $past(req));
  // R3: falling edge-mode input keeps the request
  p_edge_fall_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && !hist_clr && !req && last_q && pend && !ack_hit) |=> pend);
  // R4: masked events report masked and never fresh
  p_masked_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hist_clr && change && mask) |=> (evt_valid && evt_masked && !evt_fresh));
  // R6: acknowledge retires an edge request when no new edge arrives
  p_ack_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && ack_hit && !rise) |=> !pend);
  // R7: history clear forgets the level and reports nothing
  p_hist_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hist_clr |=> (!last_q && !evt_valid));
endmodule

// File: rtl/edge_level_irr.sv
module edge_level_irr
  import irr_pkg::*;
#(
  parameter bit SECONDARY = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  req_i,
  input  logic [7:0]  mask_i,
  input  logic        ack_i,
  input  logic [2:0]  ack_line_i,
  input  logic        hist_clr_i,
  input  logic        mode_we_i,
  input  logic [7:0]  mode_wdata_i,
  output logic [7:0]  mode_rdata_o,
  output logic [7:0]  pend_o,
  output logic [7:0]  evt_valid_o,
  output logic [7:0]  evt_masked_o,
  output logic [7:0]  evt_fresh_o
);
  logic [NLINES-1:0] mode_q;
  logic [NLINES-1:0] ack_hit;

  irr_mode_reg #(.SECONDARY(SECONDARY)) u_mode (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (mode_we_i),
    .wdata  (mode_wdata_i),
    .mode_q (mode_q)
  );

  irr_ack_dec u_ack (
    .ack      (ack_i),
    .ack_line (ack_line_i),
    .ack_hit  (ack_hit)
  );

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    irr_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .req        (req_i[g]),
      .mask       (mask_i[g]),
      .level_mode (mode_q[g]),
      .ack_hit    (ack_hit[g]),
      .hist_clr   (hist_clr_i),
      .pend       (pend_o[g]),
      .evt_valid  (evt_valid_o[g]),
      .evt_masked (evt_masked_o[g]),
      .evt_fresh  (evt_fresh_o[g])
    );
  end

  assign mode_rdata_o = mode_q;

  // R4: flags only appear together with a valid event
  p_flags_need_evt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_masked_o | evt_fresh_o) & ~evt_valid_o) == '0);
endmodule

// File: tb/edge_level_irr_bench.sv
module edge_level_irr_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req_i, mask_i, mode_wdata_i;
  logic       ack_i, hist_clr_i, mode_we_i;
  logic [2:0] ack_line_i;
  logic [7:0] mode_rdata_o, pend_o, evt_valid_o, evt_masked_o, evt_fresh_o;
  logic [7:0] s_mode, s_pend, s_valid, s_masked, s_fresh;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_level_irr u_edge_level_irr (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i), .ack_i(ack_i),
    .ack_line_i(ack_line_i), .hist_clr_i(hist_clr_i), .mode_we_i(mode_we_i),
    .mode_wdata_i(mode_wdata_i), .mode_rdata_o(mode_rdata_o), .pend_o(pend_o),
    .evt_valid_o(evt_valid_o), .evt_masked_o(evt_masked_o), .evt_fresh_o(evt_fresh_o));

  edge_level_irr #(.SECONDARY(1'b1)) u_sec (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i), .ack_i(ack_i),
    .ack_line_i(ack_line_i), .hist_clr_i(hist_clr_i), .mode_we_i(mode_we_i),
    .mode_wdata_i(mode_wdata_i), .mode_rdata_o(s_mode), .pend_o(s_pend),
    .evt_valid_o(s_valid), .evt_masked_o(s_masked), .evt_fresh_o(s_fresh));

  // {req, mask, ack, ack_line, hist_clr, exp_pend, exp_valid, exp_masked, exp_fresh}
  // Primary mode = 8'hF8: lines 0..2 edge, 3..7 level.
  localparam int NV = 12;
  localparam logic [52:0] VEC [NV] = '{
    {8'h09, 8'h00, 1'b0, 3'd0, 1'b0, 8'h09, 8'h09, 8'h00, 8'h09}, // R1 R2 R3 both rise
    {8'h08, 8'h00, 1'b0, 3'd0, 1'b0, 8'h09, 8'h01, 8'h00, 8'h00}, // R3 edge fall keeps
    {8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h01, 8'h08, 8'h00, 8'h00}, // R2 level fall clears
    {8'h01, 8'h01, 1'b0, 3'd0, 1'b0, 8'h01, 8'h01, 8'h01, 8'h00}, // R4 masked rise
    {8'h01, 8'h00, 1'b1, 3'd0, 1'b0, 8'h00, 8'h00, 8'h00, 8'h00}, // R6 edge ack clears
    {8'h09, 8'h00, 1'b1, 3'd3, 1'b0, 8'h08, 8'h08, 8'h00, 8'h08}, // R6 level ack ignored
    {8'h09, 8'h00, 1'b1, 3'd3, 1'b0, 8'h08, 8'h00, 8'h00, 8'h00}, // R6 level keeps
    {8'h09, 8'h00, 1'b0, 3'd0, 1'b1, 8'h08, 8'h00, 8'h00, 8'h00}, // R7 clear cycle
    {8'h09, 8'h00, 1'b0, 3'd0, 1'b0, 8'h09, 8'h09, 8'h00, 8'h01}, // R7 re-trigger
    {8'h0B, 8'h02, 1'b1, 3'd0, 1'b0, 8'h0A, 8'h02, 8'h02, 8'h00}, // R4 R6 masked set + ack
    {8'h0F, 8'h00, 1'b1, 3'd2, 1'b0, 8'h0E, 8'h04, 8'h00, 8'h04}, // R6 set wins over ack
    {8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 8'h06, 8'h0F, 8'h00, 8'h00}  // R2 R3 all fall
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_mode(input logic [7:0] d);
    @(negedge clk);
    mode_we_i = 1'b1; mode_wdata_i = d;
    @(negedge clk);
    mode_we_i = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_i = '0; mask_i = '0; ack_i = 1'b0; ack_line_i = '0;
    hist_clr_i = 1'b0; mode_we_i = 1'b0; mode_wdata_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset pend", pend_o, 8'h00);
    chk("R8 reset valid", evt_valid_o, 8'h00);
    chk("R8 reset fresh", evt_fresh_o, 8'h00);
    chk("R1 reset mode", mode_rdata_o, 8'h00);

    wr_mode(8'h21);
    chk("R5 primary sparse", mode_rdata_o, 8'h20);
    chk("R5 secondary sparse", s_mode, 8'h00);
    wr_mode(8'hFF);
    chk("R5 primary full", mode_rdata_o, 8'hF8);
    chk("R5 secondary full", s_mode, 8'hDE);

    for (int i = 0; i < NV; i++) begin
      {req_i, mask_i, ack_i, ack_line_i, hist_clr_i} = VEC[i][52:32];
      @(negedge clk);
      chk($sformatf("row%0d pend", i), pend_o, VEC[i][31:24]);
      chk($sformatf("row%0d valid", i), evt_valid_o, VEC[i][23:16]);
      chk($sformatf("row%0d masked", i), evt_masked_o, VEC[i][15:8]);
      chk($sformatf("row%0d fresh", i), evt_fresh_o, VEC[i][7:0]);
    end
    ack_i = 1'b0; hist_clr_i = 1'b0;

    #2 rst_n = 1'b0;
    #1;
    chk("R8 async reset pend", pend_o, 8'h00);
    chk("R8 async reset mode", mode_rdata_o, 8'h00);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule